// File: doc/BRIEF.md
# Memory Address-Stop Monitor

This block watches the processor's memory accesses and stops the machine when one of them touches an address the operator has chosen. It is armed only when the address-stop switch is on and the compute switch is in the run position. Each access comes with a two-bit tag that gives its kind: instruction fetch, indirect-address fetch, operand fetch, or the effective address of a conditional branch that was not taken. Each access also carries the address of the instruction that made the reference.

On a match the monitor latches a halt and lights the wait indicator. It records the instruction address to report at the stop. For an instruction-fetch match that address is the selected address. For the other three kinds it is one past the referencing instruction. Once the halt is latched, the monitor reads the word at the recorded address over a simple request/ready port and holds it in a display register. That word is the instruction that would have run next. A resume pulse releases the halt.

Top module: `addr_stop_monitor`

## Requirements
- R1: A halt is latched only when `stop_sw` and `run_sw` are both 1 in the cycle of the access strobe. If either switch is 0, a matching access leaves `halt` at 0.
- R2: An access with `acc_valid`=1 and `acc_addr` equal to `sel_addr` sets `halt` and `wait_lamp` to 1 in the cycle after the strobe, provided the monitor is armed and not already halted. A non-matching access leaves both at 0.
- R3: A match whose `acc_kind` is 0 (instruction fetch) loads `halt_ia` with the matched address, which equals `sel_addr`.
- R4: A match whose `acc_kind` is 1 (indirect fetch), 2 (operand fetch) or 3 (untaken branch) loads `halt_ia` with `acc_ia`+1, taken modulo 2^AW so that the all-ones address wraps to 0.
- R5: While halted, `halt`, `wait_lamp` and `halt_ia` hold their values, and any further access (matching or not) is ignored.
- R6: `mem_req` rises in the cycle after `halt` rises, never while `halt` is 0. It stays high, with `mem_addr` equal to `halt_ia`, until `mem_ready` is sampled high.
- R7: In the cycle after `mem_req` and `mem_ready` are both high, `disp_word` holds the `mem_rdata` that was sampled, `disp_valid` is 1 and `mem_req` is 0. No further read is issued during that halt.
- R8: After a synchronous reset, `halt`, `wait_lamp`, `mem_req` and `disp_valid` are 0, and `halt_ia` and `disp_word` are 0.
- R9: A `resume` pulse while halted clears `halt`, `wait_lamp`, `mem_req` and `disp_valid` in the next cycle. This also happens in the middle of a read, and resume then takes priority over `mem_ready`. A `resume` while not halted has no effect, and a match in that same cycle still halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_sw | input | 1 | Address-stop switch on |
| run_sw | input | 1 | Compute switch at run |
| sel_addr | input | AW | Operator-selected stop address |
| acc_valid | input | 1 | Processor access strobe |
| acc_kind | input | 2 | Access kind: 0 ifetch, 1 indirect, 2 operand, 3 untaken branch |
| acc_addr | input | AW | Address of the access |
| acc_ia | input | AW | Address of the instruction making the access |
| resume | input | 1 | Clear/continue pulse |
| halt | output | 1 | Halt condition latched |
| wait_lamp | output | 1 | Wait indicator |
| halt_ia | output | AW | Instruction address reported at the halt |
| mem_req | output | 1 | Display fetch request |
| mem_addr | output | AW | Display fetch address |
| mem_ready | input | 1 | Memory has data for the request |
| mem_rdata | input | DW | Memory read data |
| disp_word | output | DW | Display register |
| disp_valid | output | 1 | Display register loaded for the current halt |

## Verification
The bench drives all four access kinds against the selected address. A design that swaps the address correction would report the select address for operand stops, or the referencing instruction without the +1. The bench hits the all-ones referencing address, where a correction computed one bit wider would not wrap to 0. It sends matches while halted and with either switch off; a latch that re-arms or ignores the switches would move `halt_ia` or halt spuriously. It pulses resume during an unanswered read, together with `mem_ready`, and while idle with a match. These catch a fetch that finishes after release, a resume that beats the match, and a request raised in the same cycle as the halt.

// File: rtl/addr_stop_pkg.sv
package addr_stop_pkg;
  typedef enum logic [1:0] {
    ACC_IFETCH   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_OPERAND  = 2'd2,
    ACC_BRANCH   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/stop_compare.sv
module stop_compare
  import addr_stop_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          armed,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] acc_ia,
  input  logic [AW-1:0] sel_addr,
  output logic          hit,
  output logic [AW-1:0] report_ia
);
  localparam logic [AW-1:0] ONE = AW'(1);

  acc_kind_e kind;

  always_comb begin
    kind = acc_kind_e'(acc_kind);
    hit  = armed && acc_valid && (acc_addr == sel_addr);
    // instruction-fetch stops report the fetched address; all others
    // report the instruction after the one that made the reference
    if (kind == ACC_IFETCH) report_ia = acc_addr;
    else                    report_ia = acc_ia + ONE;
  end
endmodule

// File: rtl/halt_latch.sv
module halt_latch #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [AW-1:0] report_ia,
  input  logic          resume,
  output logic          halt,
  output logic          wait_lamp,
  output logic [AW-1:0] halt_ia
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halt      <= 1'b0;
      wait_lamp <= 1'b0;
      halt_ia   <= '0;
    end else if (halt) begin
      if (resume) begin
        halt      <= 1'b0;
        wait_lamp <= 1'b0;
      end
    end else if (hit) begin
      halt      <= 1'b1;
      wait_lamp <= 1'b1;
      halt_ia   <= report_ia;
    end
  end
endmodule

// File: rtl/display_fetch.sv
module display_fetch #(
  parameter int AW = 17,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          halt,
  input  logic          resume,
  input  logic [AW-1:0] halt_ia,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] disp_word,
  output logic          disp_valid
);
  assign mem_addr = halt_ia;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req    <= 1'b0;
      disp_valid <= 1'b0;
      disp_word  <= '0;
    end else if (!halt || resume) begin
      mem_req    <= 1'b0;
      disp_valid <= 1'b0;
    end else if (mem_req && mem_ready) begin
      mem_req    <= 1'b0;
      disp_valid <= 1'b1;
      disp_word  <= mem_rdata;
    end else if (!mem_req && !disp_valid) begin
      mem_req    <= 1'b1;
    end
  end
endmodule

// File: rtl/addr_stop_monitor.sv
module addr_stop_monitor #(
  parameter int AW = 17,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stop_sw,
  input  logic          run_sw,
  input  logic [AW-1:0] sel_addr,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] acc_ia,
  input  logic          resume,
  output logic          halt,
  output logic          wait_lamp,
  output logic [AW-1:0] halt_ia,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] disp_word,
  output logic          disp_valid
);
  logic          hit;
  logic [AW-1:0] report_ia;
  logic          armed;

  assign armed = stop_sw && run_sw;

  stop_compare #(.AW(AW)) cmp_i (
    .armed(armed), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_ia(acc_ia), .sel_addr(sel_addr),
    .hit(hit), .report_ia(report_ia)
  );

  halt_latch #(.AW(AW)) latch_i (
    .clk(clk), .rst(rst), .hit(hit), .report_ia(report_ia),
    .resume(resume), .halt(halt), .wait_lamp(wait_lamp), .halt_ia(halt_ia)
  );

  display_fetch #(.AW(AW), .DW(DW)) fetch_i (
    .clk(clk), .rst(rst), .halt(halt), .resume(resume), .halt_ia(halt_ia),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .disp_word(disp_word), .disp_valid(disp_valid)
  );
endmodule

// File: rtl/addr_stop_monitor_chk.sv
module addr_stop_monitor_chk #(
  parameter int AW = 17,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          stop_sw,
  input logic          run_sw,
  input logic [AW-1:0] sel_addr,
  input logic          acc_valid,
  input logic [1:0]    acc_kind,
  input logic [AW-1:0] acc_addr,
  input logic [AW-1:0] acc_ia,
  input logic          resume,
  input logic          halt,
  input logic          wait_lamp,
  input logic [AW-1:0] halt_ia,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] disp_word,
  input logic          disp_valid
);
  logic match_now;
  assign match_now = acc_valid && (acc_addr == sel_addr);

  assert_disarmed_R1: assert property (@(posedge clk) disable iff (rst)
    (!halt && !(stop_sw && run_sw)) |=> !halt);

  assert_halt_on_match_R2: assert property (@(posedge clk) disable iff (rst)
    (!halt && stop_sw && run_sw && match_now) |=> (halt && wait_lamp));

  assert_ifetch_ia_R3: assert property (@(posedge clk) disable iff (rst)
    (!halt && stop_sw && run_sw && match_now && acc_kind == 2'd0)
    |=> halt_ia == $past(sel_addr));

  assert_ref_ia_R4: assert property (@(posedge clk) disable iff (rst)
    (!halt && stop_sw && run_sw && match_now && acc_kind != 2'd0)
    |=> halt_ia == AW'($past(acc_ia) + AW'(1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (halt && !resume) |=> (halt && wait_lamp && $stable(halt_ia)));

  assert_req_in_halt_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> halt);

  assert_req_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && !resume) |=> (mem_req && $stable(mem_addr)));

  assert_disp_load_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && !resume)
    |=> (disp_valid && !mem_req && disp_word == $past(mem_rdata)));

  assert_resume_R9: assert property (@(posedge clk) disable iff (rst)
    (halt && resume) |=> (!halt && !wait_lamp && !mem_req && !disp_valid));
endmodule

bind addr_stop_monitor addr_stop_monitor_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/addr_stop_monitor_tb_top.sv
`timescale 1ns/1ps
module addr_stop_monitor_tb_top;
  localparam int AW = 17;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stop_sw = 1'b0, run_sw = 1'b0;
  logic [AW-1:0] sel_addr = '0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_kind = 2'd0;
  logic [AW-1:0] acc_addr = '0, acc_ia = '0;
  logic          resume = 1'b0;
  logic          halt, wait_lamp, mem_req, disp_valid;
  logic [AW-1:0] halt_ia, mem_addr;
  logic          mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata, disp_word;

  int total = 0, bad = 0, cyc = 0;
  int ready_lat = 0, lat_cnt = 0;
  bit done = 0;

  // reference model state
  bit            m_halt = 0, m_req = 0, m_dv = 0;
  logic [AW-1:0] m_ia = '0;
  logic [DW-1:0] m_disp = '0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return (32'(a) * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction
  assign mem_rdata = word_of(mem_addr);

  addr_stop_monitor #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .stop_sw(stop_sw), .run_sw(run_sw),
    .sel_addr(sel_addr), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_ia(acc_ia), .resume(resume),
    .halt(halt), .wait_lamp(wait_lamp), .halt_ia(halt_ia),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .disp_word(disp_word), .disp_valid(disp_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural model, advanced at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_halt = 0; m_req = 0; m_dv = 0; m_ia = '0; m_disp = '0;
    end else if (m_halt) begin
      if (resume) begin
        m_halt = 0; m_req = 0; m_dv = 0;
      end else if (m_req && mem_ready) begin
        m_disp = word_of(m_ia); m_dv = 1; m_req = 0;
      end else if (!m_req && !m_dv) begin
        m_req = 1;
      end
    end else if (stop_sw && run_sw && acc_valid && acc_addr == sel_addr) begin
      m_halt = 1;
      m_ia = (acc_kind == 2'd0) ? acc_addr : AW'(int'(acc_ia) + 1);
    end
    if (mem_req && !mem_ready) lat_cnt++; else lat_cnt = 0;
  end

  // ready generator
  always @(negedge clk) begin
    #2 mem_ready = mem_req && (lat_cnt >= ready_lat);
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 halt", 32'(halt), 32'(m_halt));
      check("R2 wait_lamp", 32'(wait_lamp), 32'(m_halt));
      check("R3 R4 halt_ia", 32'(halt_ia), 32'(m_ia));
      check("R6 mem_req", 32'(mem_req), 32'(m_req));
      if (m_req) check("R6 mem_addr", 32'(mem_addr), 32'(m_ia));
      check("R7 disp_valid", 32'(disp_valid), 32'(m_dv));
      check("R7 disp_word", disp_word, m_disp);
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic access(input logic [1:0] k, input logic [AW-1:0] a, input logic [AW-1:0] ia);
    @(negedge clk); #1;
    acc_valid = 1; acc_kind = k; acc_addr = a; acc_ia = ia;
    @(negedge clk); #1;
    acc_valid = 0;
  endtask

  task automatic pulse_resume();
    @(negedge clk); #1 resume = 1;
    @(negedge clk); #1 resume = 0;
  endtask

  task automatic wait_disp();
    for (int i = 0; i < 50 && !disp_valid; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    #1 rst = 0;
    @(negedge clk);
    // R8 reset state
    check("R8 halt", 32'(halt), 0);
    check("R8 wait_lamp", 32'(wait_lamp), 0);
    check("R8 mem_req", 32'(mem_req), 0);
    check("R8 disp_valid", 32'(disp_valid), 0);
    check("R8 halt_ia", 32'(halt_ia), 0);
    check("R8 disp_word", disp_word, 0);

    sel_addr = 17'h00400;
    // R1: switch combinations that must not arm
    stop_sw = 0; run_sw = 1;
    access(2'd2, 17'h00400, 17'h00010);
    check("R1 stop off", 32'(halt), 0);
    stop_sw = 1; run_sw = 0;
    access(2'd0, 17'h00400, 17'h00400);
    check("R1 run off", 32'(halt), 0);
    run_sw = 1;
    // R2: non-matching access
    access(2'd2, 17'h00401, 17'h00010);
    check("R2 no match", 32'(halt), 0);

    // R3: instruction fetch match, immediate ready
    ready_lat = 0;
    access(2'd0, 17'h00400, 17'h00400);
    check("R3 halt_ia", 32'(halt_ia), 32'h00400);
    wait_disp();
    idle(1);
    check("R7 disp word", disp_word, word_of(17'h00400));
    // R5: matches while halted are ignored
    access(2'd2, 17'h00400, 17'h01234);
    idle(1);
    check("R5 halt_ia held", 32'(halt_ia), 32'h00400);
    check("R5 still halted", 32'(halt), 1);
    check("R7 no second fetch", 32'(mem_req), 0);
    pulse_resume();
    check("R9 released", 32'(halt), 0);

    // R4: operand, indirect and branch kinds with latency
    ready_lat = 3;
    access(2'd2, 17'h00400, 17'h00100);
    check("R4 operand", 32'(halt_ia), 32'h00101);
    wait_disp(); idle(1);
    check("R7 operand disp", disp_word, word_of(17'h00101));
    pulse_resume();
    sel_addr = 17'h1F000;
    access(2'd1, 17'h1F000, 17'h02222);
    check("R4 indirect", 32'(halt_ia), 32'h02223);
    wait_disp(); pulse_resume();
    access(2'd3, 17'h1F000, 17'h1FFFF);
    check("R4 branch wrap", 32'(halt_ia), 32'h00000);
    wait_disp(); idle(1);
    check("R7 wrap disp", disp_word, word_of(17'h00000));
    pulse_resume();

    // R9: resume in the middle of an unanswered read
    ready_lat = 6;
    access(2'd2, 17'h1F000, 17'h00050);
    idle(2);
    check("R6 req pending", 32'(mem_req), 1);
    pulse_resume();
    check("R9 mid-read halt", 32'(halt), 0);
    check("R9 mid-read req", 32'(mem_req), 0);
    check("R9 mid-read dv", 32'(disp_valid), 0);
    idle(8);
    check("R9 no late load", 32'(disp_valid), 0);

    // R9: resume coinciding with ready, resume wins
    ready_lat = 0;
    access(2'd0, 17'h1F000, 17'h1F000);
    @(negedge clk); #1 resume = 1;
    @(negedge clk); #1 resume = 0;
    check("R9 resume beats ready", 32'(disp_valid), 0);
    idle(2);

    // R9: resume while idle together with a match still halts
    @(negedge clk); #1;
    resume = 1; acc_valid = 1; acc_kind = 2'd2; acc_addr = 17'h1F000; acc_ia = 17'h00777;
    @(negedge clk); #1;
    resume = 0; acc_valid = 0;
    check("R9 idle resume no effect", 32'(halt), 1);
    check("R4 idle resume ia", 32'(halt_ia), 32'h00778);
    wait_disp();
    pulse_resume();
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule